// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general purpose I/O controller. Its pins are grouped into banks of 32. Each register class is an array of 32-bit words, one word per bank. Software reaches the block over a single-cycle register bus: an address, a write strobe and write data go in, and read data comes back combinationally in the same cycle. Each pin can be an input or an output. Output values change only through two write-only words, one that sets bits and one that clears them. This lets software change one pin without a read-modify-write sequence.

Every input passes through a two-flop synchroniser. After that comes an optional stability filter and a detector. For each pin the detector is configured for edges (rising, falling or both) or for a level, with a selectable active polarity. A detection event sets a sticky interrupt status bit. If the pin's wake enable is set, the same event also sets a sticky wake status bit. Both status words are cleared by writing ones. The `irq` output is the OR of all status bits that are enabled. The `wake` output is the OR of all wake status bits.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads 0. All pins are inputs (`pin_oe` = 0), detection is off, and both `irq` and `wake` are low.
- R2: The level word at 0x004 + 4*bank shows pin n at bit n%32 of word n/32. The value is taken after two clock edges of synchronisation, and each bank reads only its own pins.
- R3: The direction word at 0x01C + 4*bank is readable and writable. A bit of 1 makes the pin an output, and `pin_oe` follows the written value one edge later.
- R4: Writing a 1 to a bit of the word at 0x034 + 4*bank drives that output high. Writing a 1 to a bit of the word at 0x04C + 4*bank drives it low. Bits written as 0 are left unchanged.
- R5: With the type bit 0 (edge mode), the rising enable (0x064 + 4*bank) and the falling enable (0x07C + 4*bank) choose which transitions set status. Either or both may be enabled, and no transition sets status when neither is enabled.
- R6: A type bit of 1 (word at 0x300 + 4*bank) selects level mode. A polarity bit of 1 (word at 0x318 + 4*bank) makes the pin active low. While the active level persists, the status bit is set again on every clock, so a clear takes hold only once the level is inactive.
- R7: When the filter bypass bit is 0 (word at 0x094 + 4*bank), a new synchronised value is accepted only after it has been seen on 3 consecutive clocks, so a 2-cycle pulse is ignored. When the bypass bit is 1, the synchronised value is used at once, so a 1-cycle pulse is detected.
- R8: Writing a 1 to a bit of the status word (0x0C4 + 4*bank) clears that bit, and writing a 0 leaves it set. If a detection event and a clear hit the same bit in the same cycle, the event wins.
- R9: `irq` is high exactly when some bank has a status bit whose enable bit is 1 (word at 0x0AC + 4*bank). The enable bit gates only `irq`; it does not gate status capture.
- R10: A wake status bit (word at 0x418 + 4*bank, cleared by writing 1) is set by the same event as the interrupt status bit, but only if its wake enable bit is 1 (word at 0x400 + 4*bank). `wake` is the OR of all wake status bits, whatever the interrupt enables are.
- R11: Reads of the set word, the clear word and any unmapped address return 0. Writes to unmapped addresses change nothing.
- R12: An event on a pin of one bank sets status only in that bank's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32*NUM_BANKS | Asynchronous pin inputs |
| pin_out | output | 32*NUM_BANKS | Output values |
| pin_oe | output | 32*NUM_BANKS | Output enables (direction) |
| irq | output | 1 | Combined enabled interrupt |
| wake | output | 1 | Combined wake status |

## Verification
A pin change made between edges shows in the level word after two rising edges. In bypass mode the change sets status, and so `irq`, on the third edge. With the filter active it lands on the sixth edge, and register writes take effect at the next edge. The bench drives every stimulus just after a falling edge and steps a counted number of falling edges. It samples 1 ns after the falling edge, so each check lands on the first cycle in which a result is due. Checks are also placed on the cycle just before, where the old value must still hold. This is how the two-cycle synchroniser, the three-clock filter and the one-cycle status latency are pinned down exactly. Level mode is checked while the active level is still present, to show a clear being overridden, and again after the level is released.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 12;
  localparam int NUM_CLASSES = 13;

  typedef enum logic [3:0] {
    RC_NONE, RC_LEVEL, RC_DIR, RC_SET, RC_CLR, RC_RISE, RC_FALL,
    RC_BYP, RC_IMSK, RC_ISTS, RC_TYPE, RC_POL, RC_WMSK, RC_WSTS
  } reg_class_e;

  typedef struct packed {
    reg_class_e cls;
    logic [3:0] bank;
  } reg_sel_t;

  // Byte offset of word 0 of each register class
  function automatic logic [ADDR_W-1:0] class_base(input reg_class_e c);
    case (c)
      RC_LEVEL: return 12'h004;
      RC_DIR:   return 12'h01C;
      RC_SET:   return 12'h034;
      RC_CLR:   return 12'h04C;
      RC_RISE:  return 12'h064;
      RC_FALL:  return 12'h07C;
      RC_BYP:   return 12'h094;
      RC_IMSK:  return 12'h0AC;
      RC_ISTS:  return 12'h0C4;
      RC_TYPE:  return 12'h300;
      RC_POL:   return 12'h318;
      RC_WMSK:  return 12'h400;
      RC_WSTS:  return 12'h418;
      default:  return '0;
    endcase
  endfunction

  // Map a byte address to (class, bank); RC_NONE when unmapped
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a, input int nbanks);
    reg_sel_t s;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] off;
    s.cls  = RC_NONE;
    s.bank = '0;
    for (int c = 1; c <= NUM_CLASSES; c++) begin
      base = class_base(reg_class_e'(4'(c)));
      off  = a - base;
      if (a >= base && off[1:0] == 2'b00 && int'(off[ADDR_W-1:2]) < nbanks) begin
        s.cls  = reg_class_e'(4'(c));
        s.bank = off[5:2];
      end
    end
    return s;
  endfunction

  // Per-bit detection: level mode compares against polarity, edge mode uses enables
  function automatic logic [WORD_W-1:0] event_hits(
    input logic [WORD_W-1:0] cur, input logic [WORD_W-1:0] prev,
    input logic [WORD_W-1:0] lvl_sel, input logic [WORD_W-1:0] act_low,
    input logic [WORD_W-1:0] rise_en, input logic [WORD_W-1:0] fall_en);
    logic [WORD_W-1:0] edges;
    logic [WORD_W-1:0] active;
    edges  = (cur & ~prev & rise_en) | (~cur & prev & fall_en);
    active = cur ^ act_low;
    return (lvl_sel & active) | (~lvl_sel & edges);
  endfunction

  // Sticky status: write-one clears, a new event wins over the clear
  function automatic logic [WORD_W-1:0] sticky_next(
    input logic [WORD_W-1:0] cur, input logic [WORD_W-1:0] hits,
    input logic [WORD_W-1:0] clr);
    return (cur & ~clr) | hits;
  endfunction
endpackage

// File: rtl/gpc_in_cond.sv
module gpc_in_cond #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic bypass,
  output logic synced,
  output logic cond
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic s1_q, s2_q, filt_q;
  logic [CW-1:0] cnt_q;
  logic differs;

  assign differs = (s2_q != filt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      if (bypass) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
      end else if (!differs) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign synced = s2_q;
  assign cond   = bypass ? s2_q : filt_q;

  // R7: with the filter active, the accepted value cannot move before the count completes
  assert_filter_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && differs && cnt_q != LAST) |=> $stable(filt_q));
endmodule

// File: rtl/gpc_bank.sv
module gpc_bank import gpc_pkg::*; #(
  parameter int FILT_LEN = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   pins_in,
  input  reg_class_e          wr_cls,
  input  logic [WORD_W-1:0]   wr_data,
  input  reg_class_e          rd_cls,
  output logic [WORD_W-1:0]   rd_data,
  output logic [WORD_W-1:0]   pin_out,
  output logic [WORD_W-1:0]   pin_oe,
  output logic                irq_req,
  output logic                wake_req
);
  logic [WORD_W-1:0] dir_q, out_q, rise_q, fall_q, byp_q, imsk_q;
  logic [WORD_W-1:0] ists_q, typ_q, pol_q, wmsk_q, wsts_q, prev_q;
  logic [WORD_W-1:0] synced_vec, cond_vec, hit_vec, irq_lines;

  for (genvar i = 0; i < WORD_W; i++) begin : g_pin
    gpc_in_cond #(.FILT_LEN(FILT_LEN)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (pins_in[i]),
      .bypass (byp_q[i]),
      .synced (synced_vec[i]),
      .cond   (cond_vec[i])
    );
  end

  assign hit_vec = event_hits(cond_vec, prev_q, typ_q, pol_q, rise_q, fall_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0; out_q  <= '0; rise_q <= '0; fall_q <= '0;
      byp_q  <= '0; imsk_q <= '0; ists_q <= '0; typ_q  <= '0;
      pol_q  <= '0; wmsk_q <= '0; wsts_q <= '0; prev_q <= '0;
    end else begin
      prev_q <= cond_vec;
      ists_q <= sticky_next(ists_q, hit_vec, (wr_cls == RC_ISTS) ? wr_data : '0);
      wsts_q <= sticky_next(wsts_q, hit_vec & wmsk_q, (wr_cls == RC_WSTS) ? wr_data : '0);
      case (wr_cls)
        RC_DIR:  dir_q  <= wr_data;
        RC_SET:  out_q  <= out_q | wr_data;
        RC_CLR:  out_q  <= out_q & ~wr_data;
        RC_RISE: rise_q <= wr_data;
        RC_FALL: fall_q <= wr_data;
        RC_BYP:  byp_q  <= wr_data;
        RC_IMSK: imsk_q <= wr_data;
        RC_TYPE: typ_q  <= wr_data;
        RC_POL:  pol_q  <= wr_data;
        RC_WMSK: wmsk_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_cls)
      RC_LEVEL: rd_data = synced_vec;
      RC_DIR:   rd_data = dir_q;
      RC_RISE:  rd_data = rise_q;
      RC_FALL:  rd_data = fall_q;
      RC_BYP:   rd_data = byp_q;
      RC_IMSK:  rd_data = imsk_q;
      RC_ISTS:  rd_data = ists_q;
      RC_TYPE:  rd_data = typ_q;
      RC_POL:   rd_data = pol_q;
      RC_WMSK:  rd_data = wmsk_q;
      RC_WSTS:  rd_data = wsts_q;
      default:  rd_data = '0;
    endcase
  end

  assign irq_lines = ists_q & imsk_q;
  assign irq_req   = |irq_lines;
  assign wake_req  = |wsts_q;
  assign pin_out   = out_q;
  assign pin_oe    = dir_q;

  assert_dir_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cls == RC_DIR) |=> (pin_oe == $past(wr_data)));

  assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cls == RC_SET) |=> (((pin_out & $past(wr_data)) == $past(wr_data)) &&
                            ((pin_out & ~$past(wr_data)) == ($past(pin_out) & ~$past(wr_data)))));

  assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cls == RC_CLR) |=> (((pin_out & $past(wr_data)) == '0) &&
                            ((pin_out & ~$past(wr_data)) == ($past(pin_out) & ~$past(wr_data)))));

  assert_edge_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ists_q & ~$past(ists_q) & ~$past(typ_q) & ~($past(rise_q) | $past(fall_q))) == '0));

  assert_sts_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cls != RC_ISTS) |=> ((ists_q & $past(ists_q)) == $past(ists_q)));

  assert_wake_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wsts_q & ~$past(wsts_q) & ~$past(wmsk_q)) == '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl import gpc_pkg::*; #(
  parameter  int NUM_BANKS = 2,
  parameter  int FILT_LEN  = 3,
  localparam int NUM_PINS  = WORD_W * NUM_BANKS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq,
  output logic                wake
);
  reg_sel_t          sel;
  reg_class_e        bank_wr [NUM_BANKS];
  reg_class_e        bank_rdc [NUM_BANKS];
  logic [WORD_W-1:0] bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] irq_vec, wake_vec;
  logic [WORD_W-1:0] rd_or;

  assign sel = decode_addr(bus_addr, NUM_BANKS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_wr[b]  = (bus_we && sel.bank == 4'(b)) ? sel.cls : RC_NONE;
    assign bank_rdc[b] = (sel.bank == 4'(b)) ? sel.cls : RC_NONE;

    gpc_bank #(.FILT_LEN(FILT_LEN)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins_in  (pin_in[b*WORD_W +: WORD_W]),
      .wr_cls   (bank_wr[b]),
      .wr_data  (bus_wdata),
      .rd_cls   (bank_rdc[b]),
      .rd_data  (bank_rd[b]),
      .pin_out  (pin_out[b*WORD_W +: WORD_W]),
      .pin_oe   (pin_oe[b*WORD_W +: WORD_W]),
      .irq_req  (irq_vec[b]),
      .wake_req (wake_vec[b])
    );
  end

  always_comb begin
    rd_or = '0;
    for (int b = 0; b < NUM_BANKS; b++) rd_or = rd_or | bank_rd[b];
  end

  assign bus_rdata = rd_or;
  assign irq       = |irq_vec;
  assign wake      = |wake_vec;

  assert_hidden_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.cls == RC_NONE || sel.cls == RC_SET || sel.cls == RC_CLR) |-> (bus_rdata == '0));

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && !wake && pin_oe == '0));
endmodule

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;
  localparam int NB = 2;
  localparam logic [11:0] A_LVL = 12'h004, A_DIR = 12'h01C, A_SET = 12'h034, A_CLR = 12'h04C,
    A_RISE = 12'h064, A_FALL = 12'h07C, A_BYP = 12'h094, A_IMSK = 12'h0AC, A_ISTS = 12'h0C4,
    A_TYPE = 12'h300, A_POL = 12'h318, A_WMSK = 12'h400, A_WSTS = 12'h418;
  localparam int K_RD = 0, K_IRQ = 1, K_WAKE = 2, K_OUT = 3, K_OE = 4;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = 12'hFFC;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NB*32-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq, wake;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct { int kind; logic [63:0] exp; string tag; } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  gpio_bank_ctrl #(.NUM_BANKS(NB), .FILT_LEN(3)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq), .wake(wake));

  function automatic logic [11:0] wa(logic [11:0] base, int bank);
    return base + 12'(4 * bank);
  endfunction

  // Monitor: compares every queued expectation 1 ns after the falling edge
  always @(negedge clk) begin
    item_t it;
    logic [63:0] act;
    #1;
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      case (it.kind)
        K_RD:    act = {32'h0, bus_rdata};
        K_IRQ:   act = {63'h0, irq};
        K_WAKE:  act = {63'h0, wake};
        K_OUT:   act = pin_out;
        default: act = pin_oe;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind %0d: actual %h expected %h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 12'hFFC;
  endtask

  task automatic chk_rd(logic [11:0] a, logic [31:0] e, string tag);
    bus_addr = a;
    sbq.push_back('{K_RD, {32'h0, e}, tag});
    @(negedge clk);
  endtask

  task automatic chk_sig(int k, logic [63:0] e, string tag);
    sbq.push_back('{k, e, tag});
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk_sig(K_IRQ, 0, "R1"); chk_sig(K_WAKE, 0, "R1"); chk_sig(K_OE, 0, "R1");
    chk_rd(wa(A_DIR, 0), 0, "R1");
    chk_rd(wa(A_ISTS, 1), 0, "R1");
    chk_rd(wa(A_WMSK, 0), 0, "R1");

    // R3 direction
    wr(wa(A_DIR, 0), 32'h0000_00FF);
    chk_sig(K_OE, 64'h0000_0000_0000_00FF, "R3");
    chk_rd(wa(A_DIR, 0), 32'hFF, "R3");

    // R4 set/clear
    wr(wa(A_SET, 0), 32'h0F);
    chk_sig(K_OUT, 64'h0F, "R4");
    wr(wa(A_SET, 0), 32'hF0);
    chk_sig(K_OUT, 64'hFF, "R4");
    wr(wa(A_CLR, 0), 32'h3C);
    chk_sig(K_OUT, 64'hC3, "R4");
    wr(wa(A_SET, 1), 32'h20);
    chk_sig(K_OUT, 64'h0000_0020_0000_00C3, "R4_R12");

    // R11 hidden and unmapped
    chk_rd(wa(A_SET, 0), 0, "R11");
    chk_rd(wa(A_CLR, 1), 0, "R11");
    chk_rd(12'h200, 0, "R11");
    wr(12'h200, 32'hFFFF_FFFF);
    wr(12'h01E, 32'hFFFF_FFFF);
    chk_rd(wa(A_DIR, 0), 32'hFF, "R11");
    chk_sig(K_OUT, 64'h0000_0020_0000_00C3, "R11");

    // R2 level readback after two edges; R5 nothing enabled -> no status
    pin_in = 64'h8000_0001_0000_0002;
    tick(1);
    chk_rd(wa(A_LVL, 0), 0, "R2");
    chk_rd(wa(A_LVL, 0), 32'h2, "R2");
    chk_rd(wa(A_LVL, 1), 32'h8000_0001, "R2_R12");
    chk_rd(wa(A_ISTS, 0), 0, "R5");
    pin_in = '0;
    tick(8);

    // R5 edge detection in bypass mode
    wr(wa(A_BYP, 0), 32'h18); wr(wa(A_RISE, 0), 32'h18);
    wr(wa(A_FALL, 0), 32'h10); wr(wa(A_IMSK, 0), 32'h18);
    pin_in[3] = 1'b1;
    tick(2); chk_sig(K_IRQ, 0, "R5");
    tick(1); chk_sig(K_IRQ, 1, "R5_R9");
    chk_rd(wa(A_ISTS, 0), 32'h8, "R5");
    chk_rd(wa(A_ISTS, 1), 0, "R12");
    wr(wa(A_ISTS, 0), 32'h0);
    chk_rd(wa(A_ISTS, 0), 32'h8, "R8");
    wr(wa(A_ISTS, 0), 32'h8);
    chk_sig(K_IRQ, 0, "R8");
    pin_in[3] = 1'b0; tick(3);
    chk_rd(wa(A_ISTS, 0), 0, "R5");
    pin_in[4] = 1'b1; tick(3);
    chk_rd(wa(A_ISTS, 0), 32'h10, "R5");
    wr(wa(A_ISTS, 0), 32'h10);
    pin_in[4] = 1'b0; tick(3);
    chk_rd(wa(A_ISTS, 0), 32'h10, "R5");
    wr(wa(A_IMSK, 0), 32'h08);
    chk_sig(K_IRQ, 0, "R9");
    chk_rd(wa(A_ISTS, 0), 32'h10, "R9");
    wr(wa(A_ISTS, 0), 32'h10);

    // R7 glitch filter on pin 6
    wr(wa(A_RISE, 0), 32'h58); wr(wa(A_IMSK, 0), 32'h40);
    pin_in[6] = 1'b1; tick(2); pin_in[6] = 1'b0; tick(8);
    chk_rd(wa(A_ISTS, 0), 0, "R7");
    pin_in[6] = 1'b1;
    tick(5); chk_sig(K_IRQ, 0, "R7");
    tick(1); chk_sig(K_IRQ, 1, "R7");
    pin_in[6] = 1'b0; tick(8);
    wr(wa(A_ISTS, 0), 32'h40);
    wr(wa(A_BYP, 0), 32'h58);
    pin_in[6] = 1'b1; tick(1); pin_in[6] = 1'b0; tick(4);
    chk_rd(wa(A_ISTS, 0), 32'h40, "R7");
    wr(wa(A_ISTS, 0), 32'h40);

    // R6 level mode on pin 40 (bank 1 bit 8)
    wr(wa(A_BYP, 1), 32'h100); wr(wa(A_IMSK, 1), 32'h100);
    wr(wa(A_POL, 1), 32'h100);
    wr(wa(A_TYPE, 1), 32'h100);
    chk_sig(K_IRQ, 0, "R6");
    tick(1); chk_sig(K_IRQ, 1, "R6");
    wr(wa(A_ISTS, 1), 32'h100);
    chk_rd(wa(A_ISTS, 1), 32'h100, "R6_R8");
    chk_rd(wa(A_ISTS, 0), 0, "R12");
    pin_in[40] = 1'b1; tick(3);
    wr(wa(A_ISTS, 1), 32'h100);
    chk_rd(wa(A_ISTS, 1), 0, "R6");
    chk_sig(K_IRQ, 0, "R6");
    wr(wa(A_POL, 1), 32'h0);
    chk_rd(wa(A_ISTS, 1), 0, "R6");
    chk_rd(wa(A_ISTS, 1), 32'h100, "R6");
    pin_in[40] = 1'b0; tick(3);
    wr(wa(A_TYPE, 1), 32'h0);
    wr(wa(A_ISTS, 1), 32'h100);
    chk_rd(wa(A_ISTS, 1), 0, "R6");

    // R10 wake on pin 3
    pin_in[3] = 1'b1; tick(3);
    chk_sig(K_WAKE, 0, "R10");
    chk_rd(wa(A_WSTS, 0), 0, "R10");
    chk_rd(wa(A_ISTS, 0), 32'h8, "R10");
    wr(wa(A_ISTS, 0), 32'h8);
    pin_in[3] = 1'b0; tick(3);
    wr(wa(A_WMSK, 0), 32'h8);
    pin_in[3] = 1'b1;
    tick(2); chk_sig(K_WAKE, 0, "R10");
    tick(1); chk_sig(K_WAKE, 1, "R10");
    chk_sig(K_IRQ, 0, "R9");
    chk_rd(wa(A_WSTS, 0), 32'h8, "R10");
    wr(wa(A_WSTS, 0), 32'h8);
    chk_sig(K_WAKE, 0, "R10");
    chk_rd(wa(A_WSTS, 0), 0, "R10");

    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule